// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Logic

This block turns the interrupt conditions of a UART receiver and transmitter into one interrupt request line and an 8-bit identification code for the CPU to read. Four sources are handled:

- a receive line status error,
- receive data ready, meaning the receive FIFO fill count has reached the trigger level,
- a receive character timeout,
- a transmit FIFO empty event.

Each source has its own enable bit. Only the highest-priority enabled source is reported.

Data-ready and timeout share one priority level and follow the live conditions, so they clear as the FIFO drains. Transmit-empty is a held event. A pending flag is set when the transmit FIFO goes from non-empty to empty. The flag clears when the CPU writes the transmit holding register, or when it reads the identification code while transmit-empty is the source being reported. When all enable bits are zero the port is in polled mode, and the identification code always shows that nothing is pending.

Top module: `uart_irq_ident`

## Requirements
- R1: After synchronous reset, with no source active and the transmit FIFO held empty, `iir[3:0]` is 1h and `irq` is 0.
- R2: If `ien[2]` and `lsr_err` are both set, `iir[3:0]` is 6h, whatever any other source is doing.
- R3: In FIFO mode, receive data ready is active while `rx_count >= rx_trig`, and it reports 4h when `ien[0]` is set. It clears as soon as the count falls below the trigger.
- R4: In FIFO mode, `rx_timeout` with `ien[0]` set reports Ch. This applies only when data ready is not active, because data ready wins within the shared level.
- R5: When `tx_empty` goes from 0 to 1, a pending transmit-empty flag is set on that clock edge. With `ien[1]` set and no higher source active, the flag reports 2h, which is the lowest priority.
- R6: A pulse on `thr_wr` clears the pending transmit-empty flag on the next clock edge.
- R7: A pulse on `iir_rd` clears the transmit-empty flag only when the current code is 2h. A read while another code is shown leaves the flag pending.
- R8: `iir[7:6]` is 2'b11 when `fifo_en` is 1 and 2'b00 otherwise. `iir[5:4]` is always 0.
- R9: With `ien == 0` (polled mode), `iir[3:0]` is 1h and `irq` is 0, whatever the sources are doing.
- R10: With `fifo_en` at 0, data ready is active for any `rx_count >= 1`, `rx_trig` is ignored, and `rx_timeout` has no effect.
- R11: `irq` is 1 exactly when `iir[3:0]` differs from 1h.
- R12: A source whose enable bit is clear is skipped, and the next enabled source is reported. The transmit-empty flag is still recorded while `ien[1]` is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFOs enabled |
| ien | input | 4 | Enables: [0] receive data and timeout, [1] transmit empty, [2] line status, [3] other (counts only toward polled mode) |
| lsr_err | input | 1 | Receive line status error condition |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_trig | input | CNT_W | Receive trigger level |
| rx_timeout | input | 1 | Character timeout condition |
| tx_empty | input | 1 | Transmit FIFO empty |
| thr_wr | input | 1 | CPU write strobe to the transmit holding register |
| iir_rd | input | 1 | CPU read strobe of the identification code |
| irq | output | 1 | Interrupt request |
| iir | output | 8 | Identification code |

## Verification
The bench targets four failure cases:

- **Shared data/timeout level.** It drives data ready and timeout together. A design that ranks timeout first would show Ch instead of 4h.
- **Trigger boundary.** It drives the count one below the trigger and exactly at it. An off-by-one compare would report data ready one word late or one word early.
- **Conditional read clear.** It reads the identification code while data ready hides a pending transmit-empty flag. A design that clears on any read would lose the 2h code once the FIFO drains.
- **Polled mode and non-FIFO mode.** It checks that a design gating on the wrong enable bits would raise `irq`. It also checks that a design still using the trigger or the timeout with FIFOs off would report the wrong code.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [3:0] {
        ID_NONE = 4'h1,
        ID_THRE = 4'h2,
        ID_RDA  = 4'h4,
        ID_LSR  = 4'h6,
        ID_CTO  = 4'hC
    } int_id_e;

    typedef struct packed {
        logic lsr;
        logic rda;
        logic cto;
        logic thre;
    } src_vec_t;

    function automatic logic [7:0] pack_iir(input logic fifo_on, input int_id_e id);
        return {fifo_on ? 2'b11 : 2'b00, 2'b00, id};
    endfunction

endpackage

// File: rtl/rx_level_cmp.sv
module rx_level_cmp #(
    parameter int CNT_W = 5
) (
    input  logic             fifo_en,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] trig,
    output logic             above
);
    always_comb begin
        if (fifo_en) above = (count >= trig);
        else         above = (count != '0);
    end
endmodule

// File: rtl/thre_latch.sv
module thre_latch (
    input  logic clk,
    input  logic rst,
    input  logic tx_empty,
    input  logic thr_wr,
    input  logic iir_rd,
    input  logic shown,
    output logic pend
);
    logic prev_empty;
    logic set_ev;
    logic clr_ev;

    assign set_ev = tx_empty && !prev_empty;
    assign clr_ev = thr_wr || (iir_rd && shown);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_empty <= 1'b1;
            pend       <= 1'b0;
        end else begin
            prev_empty <= tx_empty;
            if (clr_ev)      pend <= 1'b0;
            else if (set_ev) pend <= 1'b1;
        end
    end

    // R5
    thre_set_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_empty && !prev_empty && !thr_wr && !iir_rd) |=> pend);

    // R6
    thre_wr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        thr_wr |=> !pend);

    // R7
    thre_rd_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (iir_rd && !shown && !thr_wr && !(tx_empty && !prev_empty)) |=> pend == $past(pend));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import uart_irq_pkg::*;
(
    input  logic [3:0] ien,
    input  src_vec_t   src,
    output int_id_e    id
);
    always_comb begin
        id = ID_NONE;
        if (ien != 4'h0) begin
            if (ien[2] && src.lsr)       id = ID_LSR;
            else if (ien[0] && src.rda)  id = ID_RDA;
            else if (ien[0] && src.cto)  id = ID_CTO;
            else if (ien[1] && src.thre) id = ID_THRE;
        end
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_en,
    input  logic [3:0]       ien,
    input  logic             lsr_err,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic             rx_timeout,
    input  logic             tx_empty,
    input  logic             thr_wr,
    input  logic             iir_rd,
    output logic             irq,
    output logic [7:0]       iir
);
    logic     rda;
    logic     thre_pend;
    src_vec_t src;
    int_id_e  id;

    rx_level_cmp #(.CNT_W(CNT_W)) u_cmp (
        .fifo_en (fifo_en),
        .count   (rx_count),
        .trig    (rx_trig),
        .above   (rda)
    );

    thre_latch u_thre (
        .clk      (clk),
        .rst      (rst),
        .tx_empty (tx_empty),
        .thr_wr   (thr_wr),
        .iir_rd   (iir_rd),
        .shown    (id == ID_THRE),
        .pend     (thre_pend)
    );

    always_comb begin
        src.lsr  = lsr_err;
        src.rda  = rda;
        src.cto  = rx_timeout && fifo_en;
        src.thre = thre_pend;
    end

    irq_prio_enc u_enc (
        .ien (ien),
        .src (src),
        .id  (id)
    );

    assign iir = pack_iir(fifo_en, id);
    assign irq = (id != ID_NONE);

    // R11
    irq_match_chk: assert property (@(posedge clk) disable iff (rst)
        irq == (iir[3:0] != 4'h1));

    // R9
    polled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ien == 4'h0) |-> (!irq && iir[3:0] == 4'h1));

    // R2
    lsr_top_chk: assert property (@(posedge clk) disable iff (rst)
        (ien[2] && lsr_err) |-> iir[3:0] == 4'h6);

    // R8
    fifo_bits_chk: assert property (@(posedge clk) disable iff (rst)
        iir[7:4] == (fifo_en ? 4'hC : 4'h0));

    // R10
    nofifo_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (!fifo_en && rx_count == '0) |-> (iir[3:0] != 4'h4 && iir[3:0] != 4'hC));
endmodule

// File: tb/test_uart_irq_ident.sv
module test_uart_irq_ident;
    localparam int CNT_W = 5;

    logic             clk = 1'b0;
    logic             rst;
    logic             fifo_en;
    logic [3:0]       ien;
    logic             lsr_err;
    logic [CNT_W-1:0] rx_count;
    logic [CNT_W-1:0] rx_trig;
    logic             rx_timeout;
    logic             tx_empty;
    logic             thr_wr;
    logic             iir_rd;
    logic             irq;
    logic [7:0]       iir;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    uart_irq_ident #(.FIFO_DEPTH(16)) i_uart_irq_ident (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .ien(ien), .lsr_err(lsr_err),
        .rx_count(rx_count), .rx_trig(rx_trig), .rx_timeout(rx_timeout),
        .tx_empty(tx_empty), .thr_wr(thr_wr), .iir_rd(iir_rd), .irq(irq), .iir(iir)
    );

    // fields: fifo_en, ien[3:0], lsr_err, count[4:0], trig[4:0], timeout, expected iir[7:0]
    localparam int NV = 14;
    localparam logic [24:0] VEC [NV] = '{
        {1'b1, 4'hF, 1'b0, 5'd0,  5'd4,  1'b0, 8'hC1}, // R3 empty
        {1'b1, 4'hF, 1'b0, 5'd3,  5'd4,  1'b0, 8'hC1}, // R3 one below trigger
        {1'b1, 4'hF, 1'b0, 5'd4,  5'd4,  1'b0, 8'hC4}, // R3 at trigger
        {1'b1, 4'hF, 1'b0, 5'd9,  5'd8,  1'b0, 8'hC4}, // R3 above trigger
        {1'b1, 4'hF, 1'b1, 5'd9,  5'd8,  1'b1, 8'hC6}, // R2 line status wins
        {1'b1, 4'hF, 1'b0, 5'd2,  5'd4,  1'b1, 8'hCC}, // R4 timeout
        {1'b1, 4'hF, 1'b0, 5'd8,  5'd4,  1'b1, 8'hC4}, // R4 data ready first in shared level
        {1'b1, 4'h0, 1'b1, 5'd9,  5'd1,  1'b1, 8'hC1}, // R9 polled
        {1'b1, 4'h1, 1'b1, 5'd9,  5'd1,  1'b0, 8'hC4}, // R12 line status disabled
        {1'b1, 4'h4, 1'b0, 5'd9,  5'd1,  1'b1, 8'hC1}, // R12 data and timeout disabled
        {1'b0, 4'hF, 1'b0, 5'd1,  5'd8,  1'b0, 8'h04}, // R10 trigger ignored, R8
        {1'b0, 4'hF, 1'b0, 5'd0,  5'd1,  1'b1, 8'h01}, // R10 timeout ignored
        {1'b0, 4'hF, 1'b1, 5'd0,  5'd1,  1'b0, 8'h06}, // R8 line status without FIFO
        {1'b1, 4'hF, 1'b0, 5'd14, 5'd14, 1'b0, 8'hC4}  // R3 high trigger
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_irq(input string req);
        total++;
        if (irq !== (iir[3:0] != 4'h1)) begin
            bad++;
            $display("FAIL %s irq: got %b expected %b", req, irq, iir[3:0] != 4'h1);
        end
    endtask

    task automatic step;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got timeout expected finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; fifo_en = 1'b1; ien = 4'hF; lsr_err = 1'b0;
        rx_count = '0; rx_trig = 5'd4; rx_timeout = 1'b0;
        tx_empty = 1'b1; thr_wr = 1'b0; iir_rd = 1'b0;
        repeat (3) step;
        rst = 1'b0;
        step;
        chk("R1", iir, 8'hC1);
        chk("R1", {7'd0, irq}, 8'h00);

        for (int k = 0; k < NV; k++) begin
            {fifo_en, ien, lsr_err, rx_count, rx_trig, rx_timeout} = VEC[k][24:8];
            #1;
            chk($sformatf("vector %0d", k), iir, VEC[k][7:0]);
            chk_irq("R11");
            step;
        end

        fifo_en = 1'b1; ien = 4'hF; lsr_err = 1'b0; rx_count = '0;
        rx_trig = 5'd4; rx_timeout = 1'b0;

        // R5: non-empty then empty sets the flag
        tx_empty = 1'b0; step;
        tx_empty = 1'b1; step;
        chk("R5", iir, 8'hC2);
        chk_irq("R11");

        // R6: a write clears the flag
        thr_wr = 1'b1; step;
        thr_wr = 1'b0; #1;
        chk("R6", iir, 8'hC1);

        // R7: a read while 4h is shown keeps the flag
        tx_empty = 1'b0; step;
        tx_empty = 1'b1; step;
        rx_count = 5'd5; #1;
        chk("R7 data shown", iir, 8'hC4);
        iir_rd = 1'b1; step;
        iir_rd = 1'b0;
        rx_count = 5'd0; #1;
        chk("R7 flag kept", iir, 8'hC2);
        iir_rd = 1'b1; step;
        iir_rd = 1'b0; #1;
        chk("R7 read clear", iir, 8'hC1);

        // R12: the flag is recorded while its enable is off
        ien = 4'h5;
        tx_empty = 1'b0; step;
        tx_empty = 1'b1; step;
        chk("R12 disabled", iir, 8'hC1);
        ien = 4'hF; #1;
        chk("R12 enabled", iir, 8'hC2);

        // R9: polled mode hides the pending flag
        ien = 4'h0; #1;
        chk("R9", iir, 8'hC1);
        chk_irq("R9");
        ien = 4'hF; #1;
        chk("R9 restore", iir, 8'hC2);

        // R1: reset clears the pending flag
        rst = 1'b1; step;
        rst = 1'b0; step;
        chk("R1 after reset", iir, 8'hC1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule